// File: doc/BRIEF.md
# Four-Channel Double-Buffered Converter Code Bank

This block holds the digital data path in front of a four-channel digital-to-analog converter core. A serial front end decodes each incoming word into a write strobe, a channel number, a target selector and a data field. Data writes land in a per-channel holding register. A shared active-low load input copies every holding register into that channel's live register on the same clock edge, so all outputs can change together. If the load input is kept low, a data write goes straight into the live register.

Each channel also has its own signed offset trim and signed gain trim. A global coding bit selects whether written codes are offset binary or twos complement. Twos complement codes are turned into offset binary by flipping the most significant bit. The result is then scaled by the gain trim, shifted by the offset trim and clamped to the legal code range. An asynchronous active-low clear drives every live register to zero without needing a clock. A small sequencer blocks transfers on the first clock edge after the clear is released.

The sequencer has three states. ST_CLEAR is entered while the clear is asserted. ST_HOLD means load is high and the live registers are frozen. ST_TRACK means load is low and the live registers follow the holding registers. The transitions are:
- RELEASE_HOLD: ST_CLEAR to ST_HOLD, taken when load is high.
- RELEASE_TRACK: ST_CLEAR to ST_TRACK, taken when load is low.
- LOAD_FALL: ST_HOLD to ST_TRACK.
- LOAD_RISE: ST_TRACK to ST_HOLD.
- CLEAR_ASSERT: any state to ST_CLEAR, taken asynchronously.
- Synchronous reset: sends the sequencer to ST_HOLD.

The default channel width is 16 bits; 14 is also supported.

Top module: `qdac_regbank`

## Requirements
- R1: A write with `wr_sel` = 0 loads `wr_data` into the holding register of channel `wr_ch` only. While `load_n` is high, `code_o` does not change.
- R2: On a clock edge where `load_n` is low, all four live registers take their holding register values together. While `load_n` stays high, the live registers hold their values.
- R3: While `load_n` is held low, a data write reaches the addressed live register on the same edge that accepts it. `code_o` shows the new value one edge after the write is presented.
- R4: While `clr_n` is low, every live register is zero. This takes effect immediately, with no clock edge.
- R5: On the first clock edge after `clr_n` returns high, no transfer takes place, even if `load_n` is low. Transfers resume on the following edge.
- R6: A write with `wr_sel` = 3 sets the global coding from `wr_data[0]`: 1 selects twos complement, 0 selects offset binary. In twos complement the live code has its MSB inverted before correction.
- R7: With zero trims, the clear code appears on `code_o` as 0 in offset binary and as 2^(DW-1) (midscale) in twos complement.
- R8: A write with `wr_sel` = 2 sets the channel's signed gain trim g. The corrected code is floor(c·(2^DW+g)/2^DW) + offset, where c is the offset-binary live code. A trim change appears on `code_o` after the edge that accepts it.
- R9: A write with `wr_sel` = 1 sets the channel's signed offset trim, which is added after scaling.
- R10: The corrected code saturates at 0 and at 2^DW−1 instead of wrapping.
- R11: A synchronous reset (`rst` high at an edge) clears all holding, live and trim registers and selects offset binary. After the reset, `code_o` is all zero.
- R12: Channel k drives `code_o[k*DW +: DW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Asynchronous clear of the live registers, active low |
| load_n | input | 1 | Simultaneous load strobe, active low |
| wr_en | input | 1 | Decoded write strobe |
| wr_ch | input | 2 | Target channel |
| wr_sel | input | 2 | Target: 0 data, 1 offset, 2 gain, 3 coding |
| wr_data | input | DW | Write data |
| code_o | output | 4·DW | Corrected code per channel, channel k at bits k·DW and up |

## Verification
Every register result is due exactly one rising edge after its stimulus, because the correction path is purely combinational. This covers data writes, trim writes, coding changes, load transfers and reset. The bench therefore drives inputs just after a falling edge and samples `code_o` at the next falling edge.

The asynchronous clear is the exception: it is checked a nanosecond after `clr_n` falls, with no edge in between. The post-release blocking is checked at the first falling edge after release, and the resumed transfer one edge later. Expected values come from an arithmetic model of the trims, clamping and MSB inversion, swept over code, gain, offset, channel and coding.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_OFFS = 2'd1,
        SEL_GAIN = 2'd2,
        SEL_CTRL = 2'd3
    } wsel_e;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_HOLD  = 2'd1,
        ST_TRACK = 2'd2
    } seq_state_e;

endpackage

// File: rtl/qdac_seq.sv
module qdac_seq
    import qdac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr_n,
    input  logic load_n,
    output logic xfer_o,
    output logic in_clear_o
);

    seq_state_e st_q;
    seq_state_e st_d;

    // state register: clear is asynchronous (CLEAR_ASSERT)
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= ST_CLEAR;
        end else if (rst) begin
            st_q <= ST_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CLEAR: st_d = load_n ? ST_HOLD : ST_TRACK;   // RELEASE_HOLD / RELEASE_TRACK
            ST_HOLD:  if (!load_n) st_d = ST_TRACK;         // LOAD_FALL
            ST_TRACK: if (load_n)  st_d = ST_HOLD;          // LOAD_RISE
            default:  st_d = ST_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        xfer_o     = 1'b0;
        in_clear_o = 1'b0;
        unique case (st_q)
            ST_CLEAR: begin
                xfer_o     = 1'b0;
                in_clear_o = 1'b1;
            end
            ST_HOLD:  xfer_o = !load_n;
            ST_TRACK: xfer_o = !load_n;
            default:  xfer_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/qdac_corr.sv
module qdac_corr #(
    parameter int DW = 16
) (
    input  logic          twos,
    input  logic [DW-1:0] code,
    input  logic [DW-1:0] gain,
    input  logic [DW-1:0] offs,
    output logic [DW-1:0] y
);

    localparam int PW = 2 * DW + 3;

    logic [DW-1:0]        c_ob;
    logic signed [DW+1:0] factor;
    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] f_ext;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic signed [PW-1:0] off_ext;
    logic signed [PW-1:0] sum;
    logic signed [PW-1:0] max_ext;

    always_comb begin
        c_ob    = twos ? {~code[DW-1], code[DW-2:0]} : code;
        factor  = $signed({2'b01, {DW{1'b0}}}) + $signed({{2{gain[DW-1]}}, gain});
        a_ext   = $signed({{(PW-DW){1'b0}}, c_ob});
        f_ext   = $signed({{(PW-DW-2){factor[DW+1]}}, factor});
        prod    = a_ext * f_ext;
        scaled  = prod >>> DW;
        off_ext = $signed({{(PW-DW){offs[DW-1]}}, offs});
        sum     = scaled + off_ext;
        max_ext = $signed({{(PW-DW){1'b0}}, {DW{1'b1}}});
        if (sum[PW-1]) begin
            y = '0;
        end else if (sum > max_ext) begin
            y = '1;
        end else begin
            y = sum[DW-1:0];
        end
    end

endmodule

// File: rtl/qdac_chan.sv
module qdac_chan #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_n,
    input  logic          xfer,
    input  logic          we_data,
    input  logic          we_offs,
    input  logic          we_gain,
    input  logic [DW-1:0] wdata,
    input  logic          twos,
    output logic [DW-1:0] dac_o,
    output logic [DW-1:0] code_o
);

    logic [DW-1:0] in_q;
    logic [DW-1:0] dac_q;
    logic [DW-1:0] off_q;
    logic [DW-1:0] gain_q;
    logic [DW-1:0] in_d;

    assign in_d = we_data ? wdata : in_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q   <= '0;
            off_q  <= '0;
            gain_q <= '0;
        end else begin
            in_q <= in_d;
            if (we_offs) off_q  <= wdata;
            if (we_gain) gain_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            dac_q <= '0;
        end else if (rst) begin
            dac_q <= '0;
        end else if (xfer) begin
            dac_q <= in_d;
        end
    end

    assign dac_o = dac_q;

    qdac_corr #(.DW(DW)) u_corr (
        .twos (twos),
        .code (dac_q),
        .gain (gain_q),
        .offs (off_q),
        .y    (code_o)
    );

endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
    import qdac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             wr_en,
    input  logic [CHW-1:0]   wr_ch,
    input  logic [1:0]       wr_sel,
    input  logic [DW-1:0]    wr_data,
    output logic [NCH*DW-1:0] code_o
);

    logic              xfer;
    logic              in_clear;
    logic              twos_q;
    logic [NCH*DW-1:0] dac_flat;

    qdac_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .clr_n      (clr_n),
        .load_n     (load_n),
        .xfer_o     (xfer),
        .in_clear_o (in_clear)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            twos_q <= 1'b0;
        end else if (wr_en && (wr_sel == SEL_CTRL)) begin
            twos_q <= wr_data[0];
        end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_ch == CHW'(k));

        qdac_chan #(.DW(DW)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .clr_n   (clr_n),
            .xfer    (xfer),
            .we_data (hit && (wr_sel == SEL_DATA)),
            .we_offs (hit && (wr_sel == SEL_OFFS)),
            .we_gain (hit && (wr_sel == SEL_GAIN)),
            .wdata   (wr_data),
            .twos    (twos_q),
            .dac_o   (dac_flat[k*DW +: DW]),
            .code_o  (code_o[k*DW +: DW])
        );
    end

endmodule

// File: rtl/qdac_regbank_chk.sv
module qdac_regbank_chk #(
    parameter int NCH = 4,
    parameter int DW  = 16,
    localparam int CHW = $clog2(NCH)
) (
    input logic              clk,
    input logic              rst,
    input logic              clr_n,
    input logic              load_n,
    input logic              wr_en,
    input logic [CHW-1:0]    wr_ch,
    input logic [1:0]        wr_sel,
    input logic [DW-1:0]     wr_data,
    input logic [NCH*DW-1:0] code_o,
    input logic [NCH*DW-1:0] dac_flat,
    input logic              in_clear
);

    logic [CHW-1:0] ch_q;
    logic [DW-1:0]  d_q;

    always_ff @(posedge clk) begin
        ch_q <= wr_ch;
        d_q  <= wr_data;
    end

    AST_HOLD_WHEN_HIGH: assert property (@(posedge clk) disable iff (rst || !clr_n)
        load_n |=> $stable(dac_flat)); // R2

    AST_TRANSPARENT_WRITE: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (wr_en && wr_sel == 2'd0 && !load_n && !in_clear) |=> (dac_flat[ch_q*DW +: DW] == d_q)); // R3

    AST_CLEAR_FORCES_ZERO: assert property (@(posedge clk)
        !clr_n |-> (dac_flat == '0)); // R4

    AST_RELEASE_BLOCKED: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (in_clear && clr_n) |=> (dac_flat == '0)); // R5

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
        rst |=> (dac_flat == '0 && code_o == '0)); // R11

endmodule

bind qdac_regbank qdac_regbank_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr_n    (clr_n),
    .load_n   (load_n),
    .wr_en    (wr_en),
    .wr_ch    (wr_ch),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .code_o   (code_o),
    .dac_flat (dac_flat),
    .in_clear (in_clear)
);

// File: tb/qdac_regbank_bench.sv
module qdac_regbank_bench;

    localparam int NCH = 4;
    localparam int DW  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clr_n = 1'b1;
    logic              load_n = 1'b1;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_ch = '0;
    logic [1:0]        wr_sel = '0;
    logic [DW-1:0]     wr_data = '0;
    logic [NCH*DW-1:0] code_o;

    int checks = 0;
    int errors = 0;

    longint m_in[NCH];
    longint m_dac[NCH];
    longint m_off[NCH];
    longint m_gain[NCH];
    bit     m_twos;

    always #2 clk = ~clk;

    qdac_regbank u_qdac_regbank (
        .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel), .wr_data(wr_data),
        .code_o(code_o)
    );

    function automatic longint sx(longint v);
        return (v >= 32768) ? v - 65536 : v;
    endfunction

    function automatic longint model(int ch);
        longint c = m_dac[ch];
        longint p;
        longint s;
        if (m_twos) c = c ^ 32768;
        p = (c * (65536 + sx(m_gain[ch]))) / 65536;
        s = p + sx(m_off[ch]);
        if (s < 0) s = 0;
        if (s > 65535) s = 65535;
        return s;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(int ch, longint expv, string tag);
        logic [DW-1:0] got;
        got = code_o[ch*DW +: DW];
        checks++;
        if (got !== DW'(expv)) begin
            errors++;
            $display("FAIL %s ch%0d got %h exp %h", tag, ch, got, DW'(expv));
        end
    endtask

    task automatic chk_all(string tag);
        for (int k = 0; k < NCH; k++) chk(k, model(k), tag);
    endtask

    task automatic wr(int ch, int sel, longint d);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_sel = 2'(sel); wr_data = DW'(d);
        tick();
        wr_en = 1'b0;
        case (sel)
            0: begin
                m_in[ch] = d;
                if (!load_n) m_dac[ch] = d;
            end
            1: m_off[ch] = d;
            2: m_gain[ch] = d;
            default: m_twos = d[0];
        endcase
    endtask

    task automatic model_reset();
        for (int k = 0; k < NCH; k++) begin
            m_in[k] = 0; m_dac[k] = 0; m_off[k] = 0; m_gain[k] = 0;
        end
        m_twos = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got running exp finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        longint codes[9]  = '{0, 1, 16384, 32767, 32768, 32769, 49152, 65534, 65535};
        longint gains[5]  = '{32768, 49152, 0, 16384, 32767};
        longint offs[5]   = '{32768, 65280, 0, 256, 32767};
        model_reset();
        @(negedge clk);
        tick();
        rst = 1'b0;
        chk_all("R11 reset state");

        // R1: writes with load high touch only the holding register
        for (int k = 0; k < NCH; k++) begin
            wr(k, 0, 1000 * (k + 1) + 7);
            chk_all("R1 held output");
        end
        // R2: one-cycle load moves all channels together, R12 placement
        load_n = 1'b0;
        for (int k = 0; k < NCH; k++) m_dac[k] = m_in[k];
        tick();
        load_n = 1'b1;
        chk_all("R2 simultaneous load R12");
        tick();
        chk_all("R2 hold after load");

        // R3: transparent write with load held low
        load_n = 1'b0;
        tick();
        wr(2, 0, 12345);
        chk(2, 12345, "R3 transparent");
        chk_all("R3 others");

        // R6 R8 R9 R10 sweep
        for (int t = 0; t < 2; t++) begin
            wr(0, 3, t);
            for (int k = 0; k < NCH; k++)
                for (int ci = 0; ci < 9; ci++)
                    for (int gi = 0; gi < 5; gi++)
                        for (int oi = 0; oi < 5; oi++) begin
                            longint c; longint raw;
                            wr(k, 2, gains[gi]);
                            wr(k, 1, offs[oi]);
                            wr(k, 0, codes[ci]);
                            c = m_twos ? (codes[ci] ^ 32768) : codes[ci];
                            raw = (c * (65536 + sx(gains[gi]))) / 65536 + sx(offs[oi]);
                            if (raw < 0 || raw > 65535) chk(k, model(k), "R10 saturate");
                            else if (t == 1)            chk(k, model(k), "R6 twos");
                            else if (gains[gi] != 0)    chk(k, model(k), "R8 gain");
                            else                        chk(k, model(k), "R9 offset");
                        end
        end
        for (int k = 0; k < NCH; k++) begin
            wr(k, 2, 0);
            wr(k, 1, 0);
        end
        wr(0, 3, 0);

        // R4 R5 R7: asynchronous clear in offset binary
        load_n = 1'b1;
        for (int k = 0; k < NCH; k++) wr(k, 0, 20000 + k);
        load_n = 1'b0; for (int k = 0; k < NCH; k++) m_dac[k] = m_in[k];
        tick();
        load_n = 1'b1;
        chk_all("R2 preload");
        #1 clr_n = 1'b0;
        #1;
        for (int k = 0; k < NCH; k++) m_dac[k] = 0;
        for (int k = 0; k < NCH; k++) chk(k, 0, "R4 R7 async clear offset binary");
        @(negedge clk);
        tick();
        clr_n = 1'b1; load_n = 1'b0;
        tick();
        chk_all("R5 no transfer after release");
        for (int k = 0; k < NCH; k++) m_dac[k] = m_in[k];
        tick();
        chk_all("R5 transfer resumes");

        // R7: clear code in twos complement gives midscale
        load_n = 1'b1;
        tick();
        wr(0, 3, 1);
        #1 clr_n = 1'b0;
        #1;
        for (int k = 0; k < NCH; k++) chk(k, 32768, "R7 twos midscale");
        for (int k = 0; k < NCH; k++) m_dac[k] = 0;
        @(negedge clk);
        clr_n = 1'b1;
        tick();
        tick();

        // R11: synchronous reset clears trims and coding
        wr(1, 2, 16384);
        wr(1, 1, 500);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        model_reset();
        chk_all("R11 after reset");
        load_n = 1'b0;
        tick();
        wr(1, 0, 0);
        chk(1, 0, "R11 offset binary coding");
        load_n = 1'b1;
        tick();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule